// File: doc/BRIEF.md
# Memory response watchdog counter

This block guards the completion handshake of an attached message memory. When an access starts, an 8-bit down-counter is loaded with a configured timeout value. The counter then decrements once per clock of the peripheral bus clock until the memory answers. Each time the memory raises its ready output, the counter is reloaded with the configured value and the access counts as complete. After completion the counter holds its value until the next access begins.

If the memory does not answer in time, the counter reaches zero and stops there. On the same clock edge, a sticky timeout flag is raised. Software clears the flag by writing a 1 to its clear input. The running counter value is available on an output for status readback. A configured value of zero turns the watchdog off.

Top module: `mem_resp_watchdog`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), cnt_value is 0 and wdg_flag is 0.
- R2: When acc_start is 1 at a clock edge and wdc_cfg is not 0, cnt_value equals wdc_cfg after that edge and an access is in progress.
- R3: When mem_ready is 1 at a clock edge, wdc_cfg is not 0 and acc_start is 0, cnt_value is reloaded with wdc_cfg and the access ends, so the counter holds that value on later edges. If acc_start and mem_ready are both 1, the value is loaded and a new access begins.
- R4: While an access is in progress, acc_start and mem_ready are 0 and cnt_value is above 1, cnt_value decreases by exactly 1 per clock edge.
- R5: When cnt_value is 1 during an access and no ready or start arrives at the edge, cnt_value becomes 0 and wdg_flag becomes 1 on that edge. The counter then stays at 0 and the access ends.
- R6: wdg_flag stays 1 while flag_clr is 0. flag_clr = 1 at an edge clears the flag. If a timeout happens on the same edge as a clear, the flag is set.
- R7: While no access is in progress, cnt_value does not change unless acc_start or mem_ready arrives with wdc_cfg not 0.
- R8: While wdc_cfg is 0, acc_start and mem_ready are ignored, cnt_value holds, and wdg_flag cannot become 1. Any access in progress is abandoned, so the counter still holds after wdc_cfg becomes non-zero again.
- R9: acc_start during an access that is already in progress restarts the count from wdc_cfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start | input | 1 | One-cycle pulse marking the start of a memory access |
| mem_ready | input | 1 | Completion handshake from the memory |
| wdc_cfg | input | 8 | Configured timeout value; 0 disables the watchdog |
| flag_clr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| cnt_value | output | 8 | Current counter value |
| wdg_flag | output | 1 | Sticky timeout flag |

## Verification
The hardest situation to reach is a timeout that lands on the same edge as a flag clear. This needs an access to run its full window with no ready and no restart, and then a clear exactly on the final decrement. Directed steps arrange this with a window of 2 and a clear on the expiring edge. Random traffic uses small timeout values and sparse ready pulses, so full expiries, restarts during an access, and withdrawals of the enable in the middle of an access all occur many times.

// File: rtl/mrw_pkg.sv
// Shared types for the memory response watchdog.
package mrw_pkg;
    // Counter action chosen each cycle by the controller.
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,   // keep value and access state
        ACT_ARM   = 3'd1,   // load timeout value, access in progress
        ACT_DONE  = 3'd2,   // load timeout value, access finished
        ACT_DEC   = 3'd3,   // decrement by one
        ACT_STOP  = 3'd4,   // final decrement to zero, timeout
        ACT_ABORT = 3'd5    // watchdog disabled, drop access, hold value
    } mrw_act_e;
endpackage

// File: rtl/mrw_ctrl.sv
// Decides the counter action for the current cycle.
// Assumes: start takes priority over ready for the access state;
// a zero timeout value disables all activity.
module mrw_ctrl
    import mrw_pkg::*;
(
    input  logic     enable,
    input  logic     acc_start,
    input  logic     mem_ready,
    input  logic     busy,
    input  logic     cnt_le_one,
    output mrw_act_e act
);
    // Action priority: disable, start, ready, countdown.
    always_comb begin
        if (!enable)
            act = busy ? ACT_ABORT : ACT_HOLD;
        else if (acc_start)
            act = ACT_ARM;
        else if (mem_ready)
            act = ACT_DONE;
        else if (busy)
            act = cnt_le_one ? ACT_STOP : ACT_DEC;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/mrw_counter.sv
// Down-counter with access-in-progress state; executes the action
// chosen by the controller and reports a timeout event.
// Assumes: synchronous active-low reset, single clock.
module mrw_counter
    import mrw_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  mrw_act_e         act,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             cnt_le_one,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign cnt_le_one = (cnt <= ONE);
    assign expire     = (act == ACT_STOP);

    // Counter value and access state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else begin
            unique case (act)
                ACT_ARM:   begin cnt <= load_val; busy <= 1'b1; end
                ACT_DONE:  begin cnt <= load_val; busy <= 1'b0; end
                ACT_DEC:   cnt <= cnt - ONE;
                ACT_STOP:  begin cnt <= '0; busy <= 1'b0; end
                ACT_ABORT: busy <= 1'b0;
                default:   ;
            endcase
        end
    end

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_DEC) |=> (cnt == $past(cnt) - ONE) && busy); // R4
    AST_ARM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ARM) |=> (cnt == $past(load_val)) && busy); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && act == ACT_HOLD) |=> $stable(cnt) && !busy); // R7
endmodule

// File: rtl/mrw_flag.sv
// Sticky timeout flag with write-one-to-clear; set beats clear.
// Assumes: synchronous active-low reset.
module mrw_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    // Sticky flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_evt)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_evt) |=> !flag); // R6
endmodule

// File: rtl/mem_resp_watchdog.sv
// Memory response watchdog: loads a down-counter on access start,
// reloads it on each ready handshake, and raises a sticky flag when
// it runs down to zero without a response.
// Assumes: inputs are synchronous to clk; a zero timeout disables it.
module mem_resp_watchdog
    import mrw_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_start,
    input  logic             mem_ready,
    input  logic [CNT_W-1:0] wdc_cfg,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_value,
    output logic             wdg_flag
);
    mrw_act_e act;
    logic     busy;
    logic     cnt_le_one;
    logic     expire;
    logic     enable;

    assign enable = (wdc_cfg != '0);

    mrw_ctrl u_ctrl (
        .enable     (enable),
        .acc_start  (acc_start),
        .mem_ready  (mem_ready),
        .busy       (busy),
        .cnt_le_one (cnt_le_one),
        .act        (act)
    );

    mrw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .load_val   (wdc_cfg),
        .cnt        (cnt_value),
        .busy       (busy),
        .cnt_le_one (cnt_le_one),
        .expire     (expire)
    );

    mrw_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (expire),
        .clr     (flag_clr),
        .flag    (wdg_flag)
    );

    AST_READY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mem_ready) |=> (cnt_value == $past(wdc_cfg))); // R3
    AST_ZERO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_value == '0 && !(enable && (acc_start || mem_ready))) |=> (cnt_value == '0)); // R5
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> $stable(cnt_value) && !$rose(wdg_flag)); // R8
endmodule

// File: tb/tb_mem_resp_watchdog.sv
`timescale 1ns/1ps
module tb_mem_resp_watchdog;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_start, mem_ready, flag_clr;
    logic [7:0] wdc_cfg;
    logic [7:0] cnt_value;
    logic       wdg_flag;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Reference state built from the requirements.
    logic [7:0] m_cnt;
    logic       m_flag, m_busy;

    always #2.5 clk = ~clk;

    mem_resp_watchdog dut (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .mem_ready(mem_ready),
        .wdc_cfg(wdc_cfg), .flag_clr(flag_clr), .cnt_value(cnt_value), .wdg_flag(wdg_flag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Expected next state for one clock edge with the given inputs.
    task automatic model_edge(input logic st, input logic rd, input logic cl, input logic [7:0] w);
        logic ex;
        ex = 1'b0;
        if (w == 8'd0) begin
            m_busy = 1'b0;                      // R8
        end else if (st || rd) begin
            m_cnt = w;                          // R2 R3 R9
            m_busy = st;
        end else if (m_busy) begin
            if (m_cnt <= 8'd1) begin            // R5
                m_cnt = 8'd0;
                m_busy = 1'b0;
                ex = 1'b1;
            end else begin
                m_cnt = m_cnt - 8'd1;           // R4
            end
        end
        if (ex) m_flag = 1'b1;                  // R6 set wins
        else if (cl) m_flag = 1'b0;
    endtask

    task automatic check(input string tag);
        checks = checks + 1;
        if (cnt_value !== m_cnt) begin
            failures = failures + 1;
            $display("FAIL %s cnt_value actual=%0d expected=%0d", tag, cnt_value, m_cnt);
        end
        checks = checks + 1;
        if (wdg_flag !== m_flag) begin
            failures = failures + 1;
            $display("FAIL %s wdg_flag actual=%0d expected=%0d", tag, wdg_flag, m_flag);
        end
    endtask

    // Drive at negedge, let one edge pass, check at the next negedge.
    task automatic step(input logic st, input logic rd, input logic cl, input logic [7:0] w, input string tag);
        acc_start = st; mem_ready = rd; flag_clr = cl; wdc_cfg = w;
        @(posedge clk);
        model_edge(st, rd, cl, w);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        logic [7:0] w;
        int seed;
        seed = 32'h5eed;
        w = $urandom(seed);
        rst_n = 1'b0; acc_start = 0; mem_ready = 0; flag_clr = 0; wdc_cfg = 8'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_flag = 0; m_busy = 0;
        check("R1");
        // R7: idle holds
        repeat (3) step(0, 0, 0, 8'd5, "R7");
        // R2 load, R4 countdown, R5 expiry and stop
        step(1, 0, 0, 8'd5, "R2");
        repeat (4) step(0, 0, 0, 8'd5, "R4");
        step(0, 0, 0, 8'd5, "R5");
        repeat (3) step(0, 0, 0, 8'd5, "R5");
        // R6: sticky, then clear
        repeat (2) step(0, 0, 0, 8'd5, "R6");
        step(0, 0, 1, 8'd5, "R6");
        // R3: ready reloads and ends access
        step(1, 0, 0, 8'd6, "R3");
        repeat (2) step(0, 0, 0, 8'd6, "R3");
        step(0, 1, 0, 8'd6, "R3");
        repeat (3) step(0, 0, 0, 8'd6, "R3");
        step(1, 1, 0, 8'd6, "R3");
        step(0, 0, 0, 8'd6, "R3");
        // R9: restart in progress
        step(1, 0, 0, 8'd7, "R9");
        repeat (2) step(0, 0, 0, 8'd7, "R9");
        step(1, 0, 0, 8'd7, "R9");
        step(0, 0, 0, 8'd7, "R9");
        // R6: timeout coinciding with clear
        step(1, 0, 0, 8'd2, "R6");
        step(0, 0, 0, 8'd2, "R6");
        step(0, 0, 1, 8'd2, "R6");
        step(0, 0, 1, 8'd2, "R6");
        // R8: disabled watchdog
        step(1, 0, 0, 8'd0, "R8");
        step(0, 1, 0, 8'd0, "R8");
        step(1, 0, 0, 8'd4, "R8");
        step(0, 0, 0, 8'd4, "R8");
        repeat (6) step(0, 0, 0, 8'd0, "R8");
        repeat (6) step(0, 0, 0, 8'd4, "R8");
        // Random traffic
        w = 8'd3;
        for (int i = 0; i < 3000; i++) begin
            logic st, rd, cl;
            if (($urandom % 16) == 0)
                w = (($urandom % 12) == 0) ? 8'd0 : 8'(1 + ($urandom % 12));
            st = (($urandom % 9) == 0);
            rd = (($urandom % 11) == 0);
            cl = (($urandom % 14) == 0);
            step(st, rd, cl, w, "R4");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule